// File: doc/BRIEF.md
# Strided Delta Brick Emitter

This block sits at the output side of a convolution tile. It turns a pallet of finished output bricks into delta bricks for the next layer. A brick is 16 signed 16-bit lanes. The bricks wait in 16 per-column buffers, and each column buffer keeps the bricks of the four most recent output pallets in slots chosen by pallet index modulo 4. The engine uses one activation stage and one subtractor array, shared in time across all 16 columns.

For output column c, the engine first reads the brick that lies the next layer's stride S to the left, which is column (c − S) mod 16. When c − S is negative, that brick comes from an older pallet. The engine applies the activation function to it and holds the result. In the next cycle it reads column c of the current pallet, activates it, and subtracts the held brick lane by lane. It writes the result, with an address, to activation memory.

A row-start flag marks a pallet that opens a feature-map row. In that case, every column whose left neighbour falls in an earlier pallet is emitted as its raw activated value and not as a delta.

Top module: `delta_brick_emitter`

## Requirements
- R1: While rst_ni is low, and right after it is released, busy_o, out_valid_o and done_o are 0.
- R2: When start_i is sampled high while busy_o is 0, the engine latches stride_i, pallet_i, relu_en_i and row_start_i. busy_o then stays high for 32 cycles. The result for column c appears with out_valid_o on the 2c+2-th rising edge after the start edge, for columns 0 to 15 in ascending order. Each result is followed by one cycle with out_valid_o low. done_o pulses together with column 15, and at that same edge busy_o falls.
- R3: out_addr_o equals pallet × 16 + column, with the column in the low 4 bits and the latched pallet index above them.
- R4: Lane i of a result occupies bits [16i+15:16i]. Its value is act(current lane) − act(left lane), taken modulo 2^16. The current brick is column c in slot pallet mod 4. The left brick is column (c − S) mod 16.
- R5: When c − S < 0, the left brick is read from slot (pallet − ceil((S − c)/16)) mod 4. For example, stride 2 at column 0 reads column 14 of the previous pallet's slot.
- R6: Strides from 1 to 48 are supported. Stride 48 at column c reads column c of the slot three pallets back.
- R7: With relu_en latched as 1, the activation maps negative lanes to 0 on both operands before the subtraction. With relu_en latched as 0, the activation passes lanes through unchanged.
- R8: With row_start latched as 1, each column with c − S < 0 outputs act(current lane) in every lane with no subtraction. The other columns still output deltas.
- R9: start_i and changes to stride_i, pallet_i, relu_en_i or row_start_i while busy_o is 1 have no effect on the running pallet's results or timing.
- R10: A cycle with buf_we_i high stores buf_data_i into column buf_col_i, slot buf_slot_i. Later reads of that column and slot return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| buf_we_i | input | 1 | Column buffer write strobe |
| buf_col_i | input | 4 | Column buffer to write |
| buf_slot_i | input | 2 | Pallet slot to write |
| buf_data_i | input | 256 | Brick to store, lane i at bits [16i+15:16i] |
| start_i | input | 1 | Start emitting one pallet |
| stride_i | input | 6 | Next layer stride, 1 to 48 |
| pallet_i | input | 8 | Current output pallet index |
| relu_en_i | input | 1 | 1 selects ReLU, 0 bypass |
| row_start_i | input | 1 | Pallet opens a feature-map row |
| busy_o | output | 1 | Pallet in progress |
| out_valid_o | output | 1 | Write strobe to activation memory |
| out_addr_o | output | 12 | Write address, pallet × 16 + column |
| out_data_o | output | 256 | Delta or raw brick |
| done_o | output | 1 | Pulse with the last column of a pallet |

## Verification
The assertions assume two things about the inputs. First, every accepted start carries a stride between 1 and 48. Second, no column buffer slot that a running pallet reads is rewritten while busy_o is high. The bench loads all column buffers only between pallets and drives only legal strides. It also chooses pallet indices so that the slot wraps through all four positions, including the three-pallet lookback. When it disturbs the control inputs in mid-run, it uses another legal stride, so the assumed input range still holds.

// File: rtl/dbe_pkg.sv
package dbe_pkg;
  localparam int LANES   = 16;
  localparam int DW      = 16;
  localparam int NCOL    = 16;
  localparam int NSLOT   = 4;
  localparam int COL_W   = $clog2(NCOL);
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int STR_W   = COL_W + SLOT_W;
  localparam int DIFF_W  = STR_W + 1;
  localparam int BRICK_W = LANES * DW;
  localparam int MAX_STR = NCOL * (NSLOT - 1);

  typedef logic [LANES-1:0][DW-1:0] brick_t;
endpackage

// File: rtl/dbe_nbr_addr.sv
module dbe_nbr_addr
  import dbe_pkg::*;
(
  input  logic [COL_W-1:0]  col_i,
  input  logic [STR_W-1:0]  stride_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [COL_W-1:0]  nbr_col_o,
  output logic [SLOT_W-1:0] nbr_slot_o,
  output logic              earlier_o
);
  logic [DIFF_W-1:0] diff;

  always_comb begin
    diff       = DIFF_W'(col_i) - DIFF_W'(stride_i);
    nbr_col_o  = diff[COL_W-1:0];
    // floor(diff/NCOL) mod NSLOT is the slot offset bit field
    nbr_slot_o = slot_i + diff[COL_W+SLOT_W-1:COL_W];
    earlier_o  = diff[DIFF_W-1];
  end
endmodule

// File: rtl/dbe_act.sv
module dbe_act
  import dbe_pkg::*;
(
  input  brick_t brick_i,
  input  logic   relu_en_i,
  output brick_t brick_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign brick_o[l] = (relu_en_i && brick_i[l][DW-1]) ? '0 : brick_i[l];
  end
endmodule

// File: rtl/dbe_sub.sv
module dbe_sub
  import dbe_pkg::*;
(
  input  brick_t cur_i,
  input  brick_t left_i,
  input  logic   raw_i,
  output brick_t res_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign res_o[l] = raw_i ? cur_i[l] : cur_i[l] - left_i[l];
  end
endmodule

// File: rtl/delta_brick_emitter.sv
module delta_brick_emitter
  import dbe_pkg::*;
#(
  parameter int PIDX_W = 8,
  localparam int ADDR_W = PIDX_W + COL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               buf_we_i,
  input  logic [COL_W-1:0]   buf_col_i,
  input  logic [SLOT_W-1:0]  buf_slot_i,
  input  logic [BRICK_W-1:0] buf_data_i,
  input  logic               start_i,
  input  logic [STR_W-1:0]   stride_i,
  input  logic [PIDX_W-1:0]  pallet_i,
  input  logic               relu_en_i,
  input  logic               row_start_i,
  output logic               busy_o,
  output logic               out_valid_o,
  output logic [ADDR_W-1:0]  out_addr_o,
  output logic [BRICK_W-1:0] out_data_o,
  output logic               done_o
);
  brick_t col_buf [NCOL][NSLOT];

  logic              busy_q, phase_q, relu_q, row_q, out_valid_q, done_q;
  logic [COL_W-1:0]  col_q;
  logic [STR_W-1:0]  stride_q;
  logic [PIDX_W-1:0] pallet_q;
  logic [ADDR_W-1:0] out_addr_q;
  brick_t            hold_q, out_data_q;

  logic [COL_W-1:0]  nbr_col, rd_col;
  logic [SLOT_W-1:0] nbr_slot, rd_slot;
  logic              earlier;
  brick_t            rd_brick, act_brick, res_brick;

  always_ff @(posedge clk_i) begin
    if (buf_we_i) col_buf[buf_col_i][buf_slot_i] <= brick_t'(buf_data_i);
  end

  dbe_nbr_addr u_nbr (
    .col_i      (col_q),
    .stride_i   (stride_q),
    .slot_i     (pallet_q[SLOT_W-1:0]),
    .nbr_col_o  (nbr_col),
    .nbr_slot_o (nbr_slot),
    .earlier_o  (earlier)
  );

  // phase 0 reads left neighbour, phase 1 reads current column
  assign rd_col   = phase_q ? col_q : nbr_col;
  assign rd_slot  = phase_q ? pallet_q[SLOT_W-1:0] : nbr_slot;
  assign rd_brick = col_buf[rd_col][rd_slot];

  dbe_act u_act (
    .brick_i   (rd_brick),
    .relu_en_i (relu_q),
    .brick_o   (act_brick)
  );

  dbe_sub u_sub (
    .cur_i  (act_brick),
    .left_i (hold_q),
    .raw_i  (row_q & earlier),
    .res_o  (res_brick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      phase_q     <= 1'b0;
      relu_q      <= 1'b0;
      row_q       <= 1'b0;
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
      col_q       <= '0;
      stride_q    <= '0;
      pallet_q    <= '0;
      out_addr_q  <= '0;
      hold_q      <= '0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q   <= 1'b1;
          phase_q  <= 1'b0;
          col_q    <= '0;
          stride_q <= stride_i;
          pallet_q <= pallet_i;
          relu_q   <= relu_en_i;
          row_q    <= row_start_i;
        end
      end else if (!phase_q) begin
        hold_q  <= act_brick;
        phase_q <= 1'b1;
      end else begin
        out_valid_q <= 1'b1;
        out_data_q  <= res_brick;
        out_addr_q  <= {pallet_q, col_q};
        phase_q     <= 1'b0;
        col_q       <= col_q + 1'b1;
        if (col_q == COL_W'(NCOL - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign out_valid_o = out_valid_q;
  assign out_addr_o  = out_addr_q;
  assign out_data_o  = out_data_q;
  assign done_o      = done_q;
endmodule

// File: rtl/dbe_checker.sv
module dbe_checker
  import dbe_pkg::*;
#(
  parameter int PIDX_W = 8,
  localparam int ADDR_W = PIDX_W + COL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [STR_W-1:0]  stride_i,
  input logic              busy_o,
  input logic              out_valid_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic              done_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!busy_o && !out_valid_o && !done_o)
        else $error("outputs active in reset");
    end
  end

  p_stride_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |-> (stride_i != '0 && int'(stride_i) <= MAX_STR))
    else $error("illegal stride accepted");

  p_col_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !done_o) |=> !out_valid_o ##1
      (out_valid_o && out_addr_o[COL_W-1:0] == $past(out_addr_o[COL_W-1:0], 2) + 1'b1))
    else $error("column sequence broken");

  p_pallet_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !done_o) |=> ##1
      (out_addr_o[ADDR_W-1:COL_W] == $past(out_addr_o[ADDR_W-1:COL_W], 2)))
    else $error("pallet address changed in run");

  p_done_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_valid_o && !busy_o && out_addr_o[COL_W-1:0] == '1))
    else $error("done without last column");

  p_busy_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o)
    else $error("run ended without done");

  p_out_in_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(busy_o))
    else $error("output outside a run");
endmodule

bind delta_brick_emitter dbe_checker #(.PIDX_W(PIDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stride_i    (stride_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .out_addr_o  (out_addr_o),
  .done_o      (done_o)
);

// File: tb/delta_brick_emitter_tb.sv
`timescale 1ns/1ps
module delta_brick_emitter_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         buf_we_i;
  logic [3:0]   buf_col_i;
  logic [1:0]   buf_slot_i;
  logic [255:0] buf_data_i;
  logic         start_i;
  logic [5:0]   stride_i;
  logic [7:0]   pallet_i;
  logic         relu_en_i;
  logic         row_start_i;
  logic         busy_o;
  logic         out_valid_o;
  logic [11:0]  out_addr_o;
  logic [255:0] out_data_o;
  logic         done_o;

  int checks = 0;
  int failures = 0;
  logic [255:0] mem [16][4];

  always #2.5 clk_i = ~clk_i;

  delta_brick_emitter u_dut (
    .clk_i, .rst_ni, .buf_we_i, .buf_col_i, .buf_slot_i, .buf_data_i,
    .start_i, .stride_i, .pallet_i, .relu_en_i, .row_start_i,
    .busy_o, .out_valid_o, .out_addr_o, .out_data_o, .done_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] act_fn(input logic [15:0] v, input bit relu);
    return (relu && v[15]) ? 16'h0000 : v;
  endfunction

  function automatic logic [255:0] expect_brick(input int c, input int s, input int p,
                                                input bit relu, input bit rowst);
    int d, nc, back, ns;
    bit raw;
    logic [255:0] r;
    logic [15:0] cur, lft;
    d    = c - s;
    nc   = ((d % 16) + 16) % 16;
    back = (d < 0) ? ((-d + 15) / 16) : 0;
    ns   = (((p % 4) - back) + 4) % 4;
    raw  = rowst && (d < 0);
    for (int l = 0; l < 16; l++) begin
      cur = mem[c][p % 4][16*l +: 16];
      lft = mem[nc][ns][16*l +: 16];
      r[16*l +: 16] = raw ? act_fn(cur, relu) : act_fn(cur, relu) - act_fn(lft, relu);
    end
    return r;
  endfunction

  task automatic write_brick(input int c, input int s, input logic [255:0] b);
    @(negedge clk_i);
    buf_we_i = 1'b1; buf_col_i = 4'(c); buf_slot_i = 2'(s); buf_data_i = b;
    mem[c][s] = b;
    @(negedge clk_i);
    buf_we_i = 1'b0;
  endtask

  task automatic load_all(input int seed);
    logic [255:0] b;
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 4; s++) begin
        for (int l = 0; l < 16; l++)
          b[16*l +: 16] = 16'(c * 1103 + s * 2917 + l * 331 + seed * 4099 + c * l * 97);
        write_brick(c, s, b);
      end
  endtask

  task automatic run_pallet(input int p, input int s, input bit relu, input bit rowst,
                            input bit disturb, input string req);
    int c;
    @(negedge clk_i);
    start_i = 1'b1; stride_i = 6'(s); pallet_i = 8'(p);
    relu_en_i = relu; row_start_i = rowst;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after start", 256'(busy_o), 256'(1));
    for (int t = 1; t <= 32; t++) begin
      if (disturb && t == 5) begin
        start_i = 1'b1; stride_i = 6'd7; pallet_i = 8'(p + 1);
        relu_en_i = ~relu; row_start_i = ~rowst;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      check(out_valid_o == (t % 2 == 0), req, $sformatf("valid t=%0d", t),
            256'(out_valid_o), 256'(t % 2 == 0));
      if (t % 2 == 0 && out_valid_o) begin
        c = t / 2 - 1;
        check(out_addr_o == 12'(p * 16 + c), "R3", $sformatf("addr col %0d", c),
              256'(out_addr_o), 256'(12'(p * 16 + c)));
        check(out_data_o == expect_brick(c, s, p, relu, rowst), req,
              $sformatf("data col %0d", c), out_data_o, expect_brick(c, s, p, relu, rowst));
        check(done_o == (c == 15), "R2", $sformatf("done col %0d", c),
              256'(done_o), 256'(c == 15));
      end
    end
    check(busy_o == 1'b0, "R2", "busy cleared", 256'(busy_o), 256'(0));
    relu_en_i = 1'b0; row_start_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; buf_we_i = 1'b0; buf_col_i = '0; buf_slot_i = '0; buf_data_i = '0;
    start_i = 1'b0; stride_i = 6'd1; pallet_i = '0; relu_en_i = 1'b0; row_start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !out_valid_o && !done_o, "R1", "idle in reset",
          256'({busy_o, out_valid_o, done_o}), 256'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !out_valid_o && !done_o, "R1", "idle after reset",
          256'({busy_o, out_valid_o, done_o}), 256'(0));
  endtask

  task automatic t_wrap_arith;
    logic [255:0] a, b;
    a = mem[5][1]; b = mem[4][1];
    a[15:0] = 16'h8000; b[15:0] = 16'h0001;
    write_brick(5, 1, a);
    write_brick(4, 1, b);
    check(expect_brick(5, 1, 1, 1'b0, 1'b0) == expect_brick(5, 1, 1, 1'b0, 1'b0) &&
          expect_brick(5, 1, 1, 1'b0, 1'b0)[15:0] == 16'h7fff, "R4", "model wrap",
          256'(expect_brick(5, 1, 1, 1'b0, 1'b0)[15:0]), 256'(16'h7fff));
    run_pallet(1, 1, 1'b0, 1'b0, 1'b0, "R4/R10");
  endtask

  initial begin
    t_reset();
    load_all(1);
    run_pallet(5, 1, 1'b0, 1'b0, 1'b0, "R4/R10");   // R4 plain deltas
    run_pallet(4, 2, 1'b1, 1'b0, 1'b0, "R5/R7");    // R5 wrap to slot 3, R7 relu
    run_pallet(2, 48, 1'b0, 1'b0, 1'b0, "R6");      // R6 three pallets back
    run_pallet(7, 17, 1'b1, 1'b0, 1'b0, "R5/R7");
    run_pallet(8, 3, 1'b1, 1'b1, 1'b0, "R8");       // R8 raw row start
    run_pallet(9, 20, 1'b0, 1'b1, 1'b0, "R8");
    run_pallet(3, 5, 1'b0, 1'b0, 1'b1, "R9");       // R9 disturbed inputs
    load_all(2);
    run_pallet(6, 33, 1'b1, 1'b0, 1'b0, "R6/R10");
    t_wrap_arith();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #250000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule